// File: doc/BRIEF.md
# ADC Conversion Sequencer with Single-Shot Preemption

This block sequences a successive-approximation analog-to-digital converter. It drives a trial code to an external DAC and reads one comparator decision per cycle. Each finished result is stored in a per-channel data register. Software controls it through a one-byte control write and reads back a status byte.

The block has two modes. Scan mode converts every channel in turn for as long as `scan_run` is high. Single mode converts one channel when it is started, either by a software strobe in the control write or by a hardware trigger input. A control bit chooses which of the two starts single mode. At the end of a normal single conversion the block raises a one-cycle interrupt pulse or a one-cycle DMA request, as a second control bit chooses.

A software stop strobe aborts a single conversion. A repeated start restarts it. A start issued while scan mode is converting takes the converter for one single conversion. When that single conversion ends, by completion or by stop, scan mode resumes on the channel it lost.

Top module: `adc_seq`

## Requirements
- R1: After reset the control readback `ctrl_rd` is 0x20 (idle flag in bit 5 set, every other bit 0), and `irq_req` and `dma_req` are low.
- R2: Control bit 3 chooses the single-mode trigger. When it is 0, a write with bit 7 set starts a conversion. When it is 1, `hw_trig` high for a cycle starts a conversion and a bit-7 write starts nothing.
- R3: A single conversion tries the bits MSB first and makes one decision per cycle for 10 cycles. `cmp_in`=1 keeps the trial bit. Bit 5 of `ctrl_rd` reads 0 from the start edge and returns to 1 on the 10th edge after it. The final code is then stored for the channel on `sgl_ch`.
- R4: Control bit 4 chooses the completion request: 0 gives an `irq_req` pulse and 1 gives a `dma_req` pulse. The pulse is high for exactly one cycle, in the cycle after the completing edge, and the other output stays low.
- R5: A write with bit 6 set during a single conversion aborts it at that edge. Bit 5 returns to 1, `dac_code` keeps the partial code, the data register is not written, and no request is raised.
- R6: A bit-6 write has no effect when single mode is idle, including while scan mode is converting.
- R7: A write with both bit 7 and bit 6 set starts nothing. If a single conversion is running, that conversion is stopped.
- R8: A start during a running single conversion restarts it from the MSB. Only one completion follows, 10 edges after the restart.
- R9: A start while scan is converting cancels the scan channel and runs the single conversion. Afterwards scan reloads the cancelled channel, with `dac_code` back at 0x200.
- R10: Stopping a single conversion that preempted a scan resumes scan on the cancelled channel.
- R11: While `scan_run` is high and single mode is idle, channels 0 to NCH-1 are converted cyclically into their data registers.
- R12: Bits 7 and 6 of `ctrl_rd` always read 0. Bits 3 and 4 read back the last written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte: bit 3 trigger select, bit 4 request select, bit 6 stop, bit 7 start |
| ctrl_rd | output | 8 | Control readback, bit 5 is the idle/done flag |
| hw_trig | input | 1 | Hardware start trigger |
| scan_run | input | 1 | Enables continuous scan mode |
| sgl_ch | input | CH_W | Channel for single conversions, captured at start |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| dac_code | output | RES_W | Trial code and approximation register readback |
| ch_sel | output | CH_W | Channel being converted |
| rd_ch | input | CH_W | Data register read select |
| rd_data | output | RES_W | Data register contents for `rd_ch` |
| irq_req | output | 1 | One-cycle completion interrupt pulse |
| dma_req | output | 1 | One-cycle completion DMA request pulse |

## Verification
Two pairs of events can land on the same edge. The first pair is a start strobe and a stop strobe. The bench writes a byte with bit 7 and bit 6 both set, once while idle and once during a conversion. It judges the result by the done flag staying or returning high and by no request pulse in the following cycles. The second pair is a stop and a pending scan. The bench stops a single conversion that preempted a scan, then checks that `ch_sel` still names the cancelled scan channel and that `dac_code` restarts at the MSB trial on the next edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned TRIG_SEL_BIT = 3;
  localparam int unsigned REQ_SEL_BIT  = 4;
  localparam int unsigned IDLE_BIT     = 5;
  localparam int unsigned STOP_BIT     = 6;
  localparam int unsigned START_BIT    = 7;

  typedef enum logic [1:0] {
    ENG_HOLD  = 2'd0,
    ENG_LOAD  = 2'd1,
    ENG_ABORT = 2'd2
  } eng_cmd_e;
endpackage

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  eng_cmd_e         cmd,
  input  logic             cmp_in,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] sar,
  output logic [RES_W-1:0] result
);
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

  logic [IDX_W-1:0] idx;

  // One decision: drop the trial bit if rejected, then arm the next lower bit.
  function automatic logic [RES_W-1:0] sar_decide(input logic [RES_W-1:0] cur,
                                                   input logic [IDX_W-1:0] bit_i,
                                                   input logic keep);
    logic [RES_W-1:0] nxt;
    nxt = cur;
    if (!keep) nxt[bit_i] = 1'b0;
    if (bit_i != '0) nxt[bit_i - 1'b1] = 1'b1;
    return nxt;
  endfunction

  assign result = sar_decide(sar, idx, cmp_in);
  assign done   = busy && (idx == '0) && (cmd == ENG_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      sar  <= '0;
    end else begin
      case (cmd)
        ENG_LOAD: begin
          busy <= 1'b1;
          idx  <= TOP_IDX;
          sar  <= {1'b1, {(RES_W-1){1'b0}}};
        end
        ENG_ABORT: busy <= 1'b0;
        default: if (busy) begin
          sar <= result;
          if (idx == '0) busy <= 1'b0;
          else           idx  <= idx - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH   = 4,
  parameter int RES_W = 10,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CH_W-1:0]  wch,
  input  logic [RES_W-1:0] wdata,
  input  logic [CH_W-1:0]  rch,
  output logic [RES_W-1:0] rdata
);
  logic [RES_W-1:0] bank_view [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [RES_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (we && wch == CH_W'(g))      q <= wdata;
    end
    assign bank_view[g] = q;
  end

  assign rdata = bank_view[rch];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            hw_trig,
  input  logic            scan_run,
  input  logic [CH_W-1:0] sgl_ch,
  input  logic            eng_busy,
  input  logic            eng_done,
  output eng_cmd_e        eng_cmd,
  output logic            trig_sel,
  output logic            req_sel,
  output logic            sgl_busy,
  output logic [CH_W-1:0] ch_sel,
  output logic            irq_req,
  output logic            dma_req,
  output logic            go_evt,
  output logic            stop_evt
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

  logic            start_str, stop_str, trig_evt, scan_kill, unused_low;
  logic [CH_W-1:0] scan_ch, sgl_ch_q;

  assign unused_low = ^wr_data[2:0];
  assign start_str  = wr_en && wr_data[START_BIT];
  assign stop_str   = wr_en && wr_data[STOP_BIT];
  assign trig_evt   = trig_sel ? hw_trig : start_str;
  assign go_evt     = trig_evt && !stop_str;
  assign stop_evt   = stop_str && sgl_busy;
  assign scan_kill  = !scan_run && !sgl_busy && eng_busy;
  assign ch_sel     = sgl_busy ? sgl_ch_q : scan_ch;

  // Stop beats start, start beats scan housekeeping.
  always_comb begin
    if (stop_evt)                                  eng_cmd = ENG_ABORT;
    else if (go_evt)                               eng_cmd = ENG_LOAD;
    else if (scan_kill)                            eng_cmd = ENG_ABORT;
    else if (!eng_busy && scan_run && !sgl_busy)   eng_cmd = ENG_LOAD;
    else                                           eng_cmd = ENG_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_sel <= 1'b0;
      req_sel  <= 1'b0;
      sgl_busy <= 1'b0;
      sgl_ch_q <= '0;
      scan_ch  <= '0;
      irq_req  <= 1'b0;
      dma_req  <= 1'b0;
    end else begin
      if (wr_en) begin
        trig_sel <= wr_data[TRIG_SEL_BIT];
        req_sel  <= wr_data[REQ_SEL_BIT];
      end
      if (stop_evt) begin
        sgl_busy <= 1'b0;
      end else if (go_evt) begin
        sgl_busy <= 1'b1;
        sgl_ch_q <= sgl_ch;
      end else if (eng_done && sgl_busy) begin
        sgl_busy <= 1'b0;
      end
      if (eng_done && !sgl_busy)
        scan_ch <= (scan_ch == LAST_CH) ? '0 : scan_ch + 1'b1;
      irq_req <= eng_done && sgl_busy && !req_sel;
      dma_req <= eng_done && sgl_busy &&  req_sel;
    end
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int RES_W = 10,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       ctrl_rd,
  input  logic             hw_trig,
  input  logic             scan_run,
  input  logic [CH_W-1:0]  sgl_ch,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [CH_W-1:0]  ch_sel,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [RES_W-1:0] rd_data,
  output logic             irq_req,
  output logic             dma_req
);
  eng_cmd_e         eng_cmd;
  logic             eng_busy, eng_done, trig_sel, req_sel, sgl_busy;
  logic             go_evt, stop_evt;
  logic [RES_W-1:0] eng_result;

  adc_seq_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hw_trig(hw_trig), .scan_run(scan_run), .sgl_ch(sgl_ch),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_cmd(eng_cmd),
    .trig_sel(trig_sel), .req_sel(req_sel), .sgl_busy(sgl_busy),
    .ch_sel(ch_sel), .irq_req(irq_req), .dma_req(dma_req),
    .go_evt(go_evt), .stop_evt(stop_evt)
  );

  adc_sar_core #(.RES_W(RES_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cmd(eng_cmd), .cmp_in(cmp_in),
    .busy(eng_busy), .done(eng_done), .sar(dac_code), .result(eng_result)
  );

  adc_result_bank #(.NCH(NCH), .RES_W(RES_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(eng_done), .wch(ch_sel),
    .wdata(eng_result), .rch(rd_ch), .rdata(rd_data)
  );

  assign ctrl_rd = {2'b00, !sgl_busy, req_sel, trig_sel, 3'b000};
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [7:0]       ctrl_rd,
  input logic [RES_W-1:0] dac_code,
  input logic             irq_req,
  input logic             dma_req,
  input logic             go_evt,
  input logic             stop_evt
);
  a_r4_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);
  a_r4_dma_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_req && dma_req));
  a_r5_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> ctrl_rd[IDLE_BIT]);
  a_r5_no_req_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!irq_req && !dma_req));
  a_r5_partial_kept: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> $stable(dac_code));
  a_r7_stop_wins_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[START_BIT] && wr_data[STOP_BIT] && !ctrl_rd[IDLE_BIT])
      |=> ctrl_rd[IDLE_BIT]);
  a_r8_start_loads_msb: assert property (@(posedge clk) disable iff (!rst_n)
    go_evt |=> (!ctrl_rd[IDLE_BIT] && dac_code == {1'b1, {(RES_W-1){1'b0}}}));
  a_r12_strobes_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[7:6] == 2'b00);
endmodule

bind adc_seq adc_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .ctrl_rd(ctrl_rd), .dac_code(dac_code), .irq_req(irq_req),
  .dma_req(dma_req), .go_evt(go_evt), .stop_evt(stop_evt)
);

// File: tb/sim_adc_seq.sv
`timescale 1ns/1ps
module sim_adc_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       hw_trig = 1'b0;
  logic       scan_run = 1'b0;
  logic [1:0] sgl_ch = 2'd0;
  logic [1:0] rd_ch = 2'd0;
  logic       cmp_in;
  logic [7:0] ctrl_rd;
  logic [9:0] dac_code, rd_data;
  logic [1:0] ch_sel;
  logic       irq_req, dma_req;
  logic [9:0] vin [4];
  int checks = 0, fails = 0, irq_cnt = 0, dma_cnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // Comparator model: keep the trial code if it does not exceed the input.
  assign cmp_in = (dac_code <= vin[ch_sel]);

  adc_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .hw_trig(hw_trig), .scan_run(scan_run),
    .sgl_ch(sgl_ch), .cmp_in(cmp_in), .dac_code(dac_code),
    .ch_sel(ch_sel), .rd_ch(rd_ch), .rd_data(rd_data),
    .irq_req(irq_req), .dma_req(dma_req)
  );

  always @(posedge clk) begin
    if (irq_req) irq_cnt++;
    if (dma_req) dma_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  function automatic logic [9:0] partial_code(input logic [9:0] v, input int n);
    logic [9:0] keep_mask;
    keep_mask = 10'h3FF << (10 - n);
    return (v & keep_mask) | (10'h200 >> n);
  endfunction

  task automatic t_reset();
    chk(ctrl_rd == 8'h20, "R1 reset ctrl_rd", ctrl_rd, 8'h20);
    chk(!irq_req && !dma_req, "R1 reset requests", {irq_req, dma_req}, 0);
  endtask

  task automatic t_single(input logic [1:0] ch, input logic [9:0] v, input bit use_dma);
    int i0, d0;
    vin[ch] = v; sgl_ch = ch; rd_ch = ch;
    i0 = irq_cnt; d0 = dma_cnt;
    wr(use_dma ? 8'h90 : 8'h80);
    chk(ctrl_rd[5] == 1'b0, "R3 busy after start", ctrl_rd[5], 0);
    repeat (9) @(negedge clk);
    chk(ctrl_rd[5] == 1'b0, "R3 still busy at 9 edges", ctrl_rd[5], 0);
    @(negedge clk);
    chk(ctrl_rd[5] == 1'b1, "R3 done at 10 edges", ctrl_rd[5], 1);
    chk(rd_data == v, "R3 result stored", rd_data, v);
    chk({irq_req, dma_req} == (use_dma ? 2'b01 : 2'b10), "R4 request level",
        {irq_req, dma_req}, use_dma ? 1 : 2);
    @(negedge clk);
    chk(!irq_req && !dma_req, "R4 request one cycle", {irq_req, dma_req}, 0);
    chk((irq_cnt - i0) == (use_dma ? 0 : 1) && (dma_cnt - d0) == (use_dma ? 1 : 0),
        "R4 request count", (irq_cnt - i0) * 16 + (dma_cnt - d0), use_dma ? 1 : 16);
  endtask

  task automatic t_hw();
    wr(8'h08);
    wr(8'h88);
    chk(ctrl_rd[5] == 1'b1, "R2 sw start ignored in hw mode", ctrl_rd[5], 1);
    vin[0] = 10'h155; sgl_ch = 2'd0; rd_ch = 2'd0;
    @(negedge clk); hw_trig = 1'b1;
    @(negedge clk); hw_trig = 1'b0;
    chk(ctrl_rd[5] == 1'b0, "R2 hw trigger starts", ctrl_rd[5], 0);
    repeat (10) @(negedge clk);
    chk(ctrl_rd[5] == 1'b1 && rd_data == 10'h155, "R2 hw conversion result",
        rd_data, 10'h155);
    wr(8'h00);
  endtask

  task automatic t_stop();
    int i0;
    logic [9:0] exp_p;
    vin[1] = 10'h2C3; sgl_ch = 2'd1; rd_ch = 2'd1;
    i0 = irq_cnt;
    exp_p = partial_code(10'h2C3, 3);
    wr(8'h80);
    repeat (2) @(negedge clk);
    wr(8'h40);
    chk(ctrl_rd[5] == 1'b1, "R5 idle after stop", ctrl_rd[5], 1);
    chk(dac_code == exp_p, "R5 partial code kept", dac_code, exp_p);
    repeat (12) @(negedge clk);
    chk(rd_data == 10'h3FF, "R5 data not written", rd_data, 10'h3FF);
    chk(dac_code == exp_p, "R5 partial code still held", dac_code, exp_p);
    chk(irq_cnt == i0, "R5 no request on stop", irq_cnt - i0, 0);
  endtask

  task automatic t_both();
    int i0;
    i0 = irq_cnt;
    wr(8'hC0);
    chk(ctrl_rd[5] == 1'b1, "R7 idle start+stop starts nothing", ctrl_rd[5], 1);
    sgl_ch = 2'd3;
    wr(8'h80);
    repeat (2) @(negedge clk);
    wr(8'hC0);
    chk(ctrl_rd[5] == 1'b1, "R7 busy start+stop stops", ctrl_rd[5], 1);
    repeat (12) @(negedge clk);
    chk(ctrl_rd[5] == 1'b1 && irq_cnt == i0, "R7 no conversion followed",
        irq_cnt - i0, 0);
  endtask

  task automatic t_restart();
    int i0;
    vin[2] = 10'h0F0; sgl_ch = 2'd2; rd_ch = 2'd2;
    i0 = irq_cnt;
    wr(8'h80);
    repeat (4) @(negedge clk);
    wr(8'h80);
    repeat (9) @(negedge clk);
    chk(ctrl_rd[5] == 1'b0, "R8 restart extends busy", ctrl_rd[5], 0);
    @(negedge clk);
    chk(ctrl_rd[5] == 1'b1 && rd_data == 10'h0F0, "R8 restart result", rd_data, 10'h0F0);
    @(negedge clk);
    chk(irq_cnt - i0 == 1, "R8 single completion", irq_cnt - i0, 1);
  endtask

  task automatic t_readback();
    wr(8'hC8);
    chk(ctrl_rd == 8'h28, "R12 strobes read zero", ctrl_rd, 8'h28);
    wr(8'h40);
    chk(ctrl_rd == 8'h20, "R6 idle stop no effect", ctrl_rd, 8'h20);
  endtask

  task automatic t_scan();
    vin[0] = 10'h011; vin[1] = 10'h122; vin[2] = 10'h233; vin[3] = 10'h344;
    scan_run = 1'b1;
    repeat (60) @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      rd_ch = 2'(c); #0.1;
      chk(rd_data == vin[c], "R11 scan result", rd_data, vin[c]);
    end
    vin[0] = 10'h3C0; vin[1] = 10'h001; vin[2] = 10'h2AA; vin[3] = 10'h155;
    wr(8'h40);
    chk(ctrl_rd[5] == 1'b1, "R6 stop during scan ignored", ctrl_rd[5], 1);
    repeat (60) @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      rd_ch = 2'(c); #0.1;
      chk(rd_data == vin[c], "R6 scan continues after stop", rd_data, vin[c]);
    end
  endtask

  task automatic t_preempt();
    int i0;
    i0 = irq_cnt;
    while (ch_sel != 2'd2) @(negedge clk);
    repeat (3) @(negedge clk);
    sgl_ch = 2'd0;
    wr(8'h80);
    chk(ch_sel == 2'd0 && ctrl_rd[5] == 1'b0, "R9 single takes converter", ch_sel, 0);
    repeat (9) @(negedge clk);
    chk(ctrl_rd[5] == 1'b0, "R9 single still running", ctrl_rd[5], 0);
    @(negedge clk);
    chk(ctrl_rd[5] == 1'b1 && irq_req, "R9 single completes", irq_cnt - i0, 0);
    chk(ch_sel == 2'd2, "R9 scan resumes cancelled channel", ch_sel, 2);
    @(negedge clk);
    chk(dac_code == 10'h200 && ch_sel == 2'd2, "R9 scan reloads", dac_code, 10'h200);
  endtask

  task automatic t_stop_preempt();
    int i0;
    i0 = irq_cnt;
    while (ch_sel != 2'd1) @(negedge clk);
    repeat (3) @(negedge clk);
    sgl_ch = 2'd3;
    wr(8'h80);
    repeat (2) @(negedge clk);
    wr(8'h40);
    chk(ctrl_rd[5] == 1'b1 && ch_sel == 2'd1, "R10 stop returns to scan channel", ch_sel, 1);
    @(negedge clk);
    chk(dac_code == 10'h200, "R10 scan restarts", dac_code, 10'h200);
    repeat (3) @(negedge clk);
    chk(irq_cnt == i0, "R10 no request after stop", irq_cnt - i0, 0);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) vin[c] = 10'h000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single(2'd2, 10'h2A5, 1'b0);
    t_single(2'd1, 10'h3FF, 1'b1);
    t_single(2'd3, 10'h000, 1'b0);
    t_hw();
    t_stop();
    t_both();
    t_restart();
    t_readback();
    wr(8'h00);
    t_scan();
    t_preempt();
    t_stop_preempt();
    scan_run = 1'b0;
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule